// File: doc/BRIEF.md
# Early-Terminating Sequential Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns the low 32 bits of the product. It consumes the multiplier one byte per cycle, starting from the least significant byte. It finishes as soon as the remaining upper bytes are pure sign extension: all zeros for a non-negative multiplier, or all ones for a negative one. Small multipliers therefore finish in one step, and full-width values take four.

A caller raises `start_i` for one cycle with both operands on the inputs. The block captures the operands and raises `busy_o` while it works. When the result is ready it drops `busy_o` and pulses `done_o`. The port `cycles_used_o` reports how many steps beyond the first were needed. The product and this count stay on the outputs until the next accepted start.

Top module: `mul_early_term`

## Requirements
- R1: The operands are captured in the cycle `start_i` is accepted. Changes on `mcand_i` or `mplier_i` while `busy_o` is high do not affect `product_o`.
- R2: For a non-negative multiplier, `cycles_used_o` is 0 when bits 31:8 are all zero. It is 1 when only bits 31:16 are zero, 2 when only bits 31:24 are zero, and 3 otherwise.
- R3: For a multiplier with bit 31 set, the rule of R2 is applied to its bitwise inverse. For example, 0xFFFFFF00 gives 0, 0xFFFF8000 gives 1 and 0x80000000 gives 3.
- R4: After an accepted start, `busy_o` is high from the next cycle for exactly `cycles_used_o`+1 cycles.
- R5: `done_o` is high for exactly one cycle, immediately after the last busy cycle, and `busy_o` is low in that cycle.
- R6: A `start_i` seen while `busy_o` is high is ignored. The running operation, its step count and its result are unchanged.
- R7: When `done_o` is high, `product_o` equals the low 32 bits of `mcand_i`×`mplier_i` as captured. This includes negative multipliers that terminate early.
- R8: After reset, `busy_o`, `done_o`, `product_o` and `cycles_used_o` are all zero.
- R9: While idle with no start, `product_o` and `cycles_used_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; accepted only when not busy |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier, decides the step count |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-ready pulse |
| product_o | output | 32 | Low 32 bits of the product |
| cycles_used_o | output | 2 | Extra steps taken beyond the first |

## Verification
The assertions assume that reset is applied before the first edge. Apart from that, they assume nothing about `start_i`. A start may arrive in any cycle, including while busy or in the `done_o` cycle, and the properties on step count and operand capture must still hold. The stimulus drives deliberate starts during busy periods and changes operands while busy. It also mixes positive and negative multipliers at every byte boundary with random magnitudes, so each termination length is reached from both signs.

// File: rtl/mul_et_pkg.sv
`timescale 1ns/1ps
package mul_et_pkg;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_DIGIT_W = 8;
endpackage

// File: rtl/mul_et_len.sv
`timescale 1ns/1ps
// Picks the last digit index: lowest k whose higher digits are pure sign extension.
module mul_et_len #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIGIT_W = 8,
  localparam int unsigned N_DIG  = DATA_W / DIGIT_W,
  localparam int unsigned IDX_W  = $clog2(N_DIG),
  localparam int unsigned HI_W   = DATA_W - DIGIT_W
) (
  input  logic [HI_W-1:0]  upper_i,   // operand bits DATA_W-1 : DIGIT_W
  output logic [IDX_W-1:0] last_idx_o
);
  logic             sign;
  logic [N_DIG-2:0] hi_ext;

  assign sign = upper_i[HI_W-1];

  genvar k;
  generate
    for (k = 0; k < N_DIG - 1; k++) begin : g_ext
      localparam int unsigned LO = k * DIGIT_W;
      assign hi_ext[k] = ~|(upper_i[HI_W-1:LO] ^ {(HI_W-LO){sign}});
    end
  endgenerate

  always_comb begin
    last_idx_o = IDX_W'(N_DIG - 1);
    for (int i = N_DIG - 2; i >= 0; i--) begin
      if (hi_ext[i]) last_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mul_et_ctrl.sv
`timescale 1ns/1ps
module mul_et_ctrl #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] n_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q, n_q;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (idx_q == n_q);
  assign idx_o  = idx_q;
  assign n_o    = n_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      n_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        n_q    <= last_idx_i;
      end else if (busy_q) begin
        if (idx_q == n_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R4
  a_r4_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> busy_q);
  a_r4_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= n_q));
  // R5
  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q == n_q) |=> (done_q && !busy_q));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  a_r6_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(n_q));
endmodule

// File: rtl/mul_et_acc.sv
`timescale 1ns/1ps
// Operand registers and running sum; one digit per step.
module mul_et_acc #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DIGIT_W = 8,
  localparam int unsigned N_DIG  = DATA_W / DIGIT_W,
  localparam int unsigned IDX_W  = $clog2(N_DIG),
  localparam int unsigned SH_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              last_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] mcand_i,
  input  logic [DATA_W-1:0] mplier_i,
  output logic [DATA_W-1:0] product_o
);
  logic [DATA_W-1:0]  a_q, b_q, acc_q;
  logic [SH_W-1:0]    sh;
  logic [DIGIT_W-1:0] digit;
  logic [DATA_W-1:0]  term, corr;

  always_comb begin
    sh    = SH_W'(idx_i) * SH_W'(DIGIT_W);
    digit = DIGIT_W'(b_q >> sh);
    term  = (a_q * DATA_W'(digit)) << sh;
    // Negative multiplier stopping early: the ones above this digit weigh -2^(sh+DIGIT_W).
    corr  = (last_i && b_q[DATA_W-1]) ? (a_q << (sh + SH_W'(DIGIT_W))) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      a_q   <= mcand_i;
      b_q   <= mplier_i;
      acc_q <= '0;
    end else if (step_i) begin
      acc_q <= acc_q + term - corr;
    end
  end

  assign product_o = acc_q;

  // R1
  a_r1_ops_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> ($stable(a_q) && $stable(b_q)));
  // R9
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/mul_early_term.sv
`timescale 1ns/1ps
module mul_early_term
  import mul_et_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned DIGIT_W = DEF_DIGIT_W,
  localparam int unsigned N_DIG  = DATA_W / DIGIT_W,
  localparam int unsigned IDX_W  = $clog2(N_DIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mcand_i,
  input  logic [DATA_W-1:0] mplier_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] product_o,
  output logic [IDX_W-1:0]  cycles_used_o
);
  logic             load, step, last;
  logic [IDX_W-1:0] idx, last_idx;

  mul_et_len #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_len (
    .upper_i    (mplier_i[DATA_W-1:DIGIT_W]),
    .last_idx_o (last_idx)
  );

  mul_et_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_idx_i (last_idx),
    .load_o     (load),
    .step_o     (step),
    .last_o     (last),
    .idx_o      (idx),
    .n_o        (cycles_used_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  mul_et_acc #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .idx_i     (idx),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
  );

  // R7: result is published exactly when done is pulsed
  a_r7_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/mul_early_term_bench.sv
`timescale 1ns/1ps
module mul_early_term_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] prod;
  logic [1:0]  cyc;

  int n_run = 0, n_fail = 0;
  bit wd_hit = 0, finished = 0;

  always #4 clk = ~clk;

  mul_early_term u_mul_early_term (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mcand_i(a), .mplier_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod), .cycles_used_o(cyc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_n(input logic [31:0] v);
    logic [31:0] c;
    c = v[31] ? ~v : v;
    if (c < 32'h100) return 0;
    else if (c < 32'h1_0000) return 1;
    else if (c < 32'h100_0000) return 2;
    else return 3;
  endfunction

  // behavioural reference
  bit m_busy = 0, m_done = 0;
  int m_rem = 0;
  logic [31:0] m_pend = '0, m_prod = '0;
  logic [1:0]  m_cyc = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rem = 0; m_prod = '0; m_cyc = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_rem == 0) begin m_busy = 0; m_done = 1; m_prod = m_pend; end
        else m_rem--;
      end else if (start) begin
        m_busy = 1;
        m_rem  = ref_n(b);
        m_cyc  = 2'(ref_n(b));
        m_pend = a * b;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !wd_hit && !finished) begin
      chk(busy == m_busy, "R4 busy", 32'(busy), 32'(m_busy));
      chk(done == m_done, "R5 done", 32'(done), 32'(m_done));
      chk(cyc == m_cyc, "R2 cycles_used", 32'(cyc), 32'(m_cyc));
      if (!m_busy) chk(prod == m_prod, "R7 product", prod, m_prod);
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input int exp_n, input string tag);
    int cnt;
    @(negedge clk); start = 1; a = x; b = y;
    @(negedge clk); start = 0;
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == exp_n + 1, "R4 busy length", 32'(cnt), 32'(exp_n + 1));
    chk(done == 1'b1, "R5 done after last step", 32'(done), 32'd1);
    chk(cyc == 2'(exp_n), tag, 32'(cyc), 32'(exp_n));
    chk(prod == x * y, "R7 product", prod, x * y);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_hit = 1;
    n_run++; n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] p1;
    int cnt;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 0 && done == 0, "R8 reset flags", {30'd0, busy, done}, 32'd0);
    chk(prod == 0, "R8 reset product", prod, 32'd0);
    chk(cyc == 0, "R8 reset cycles_used", 32'(cyc), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 positive boundaries
    run_op(32'h1234_5678, 32'h0000_0005, 0, "R2 byte0 only");
    run_op(32'h1234_5678, 32'h0000_00FF, 0, "R2 0xFF");
    run_op(32'hDEAD_BEEF, 32'h0000_0100, 1, "R2 0x100");
    run_op(32'hDEAD_BEEF, 32'h0000_1234, 1, "R2 two bytes");
    run_op(32'h0BAD_F00D, 32'h0012_3456, 2, "R2 three bytes");
    run_op(32'h0BAD_F00D, 32'h1234_5678, 3, "R2 four bytes");
    run_op(32'h0000_0007, 32'h0000_0000, 0, "R2 zero");
    // R3 negative multipliers
    run_op(32'h1357_9BDF, 32'hFFFF_FF00, 0, "R3 0xFFFFFF00");
    run_op(32'h1357_9BDF, 32'hFFFF_FF80, 0, "R3 0xFFFFFF80");
    run_op(32'h1357_9BDF, 32'hFFFF_FFFF, 0, "R3 minus one");
    run_op(32'hCAFE_1234, 32'hFFFF_8000, 1, "R3 0xFFFF8000");
    run_op(32'hCAFE_1234, 32'hFF80_0001, 2, "R3 0xFF800001");
    run_op(32'hCAFE_1234, 32'h8000_0000, 3, "R3 0x80000000");

    // R6 start while busy is ignored
    @(negedge clk); start = 1; a = 32'h0101_0101; b = 32'h1234_5678;
    p1 = 32'h0101_0101 * 32'h1234_5678;
    @(negedge clk); a = 32'h7777_7777; b = 32'h0000_0003;
    @(negedge clk); @(negedge clk); start = 0;
    cnt = 2;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == 4, "R6 busy length unchanged", 32'(cnt), 32'd4);
    chk(prod == p1, "R6 product of first op", prod, p1);
    chk(cyc == 2'd3, "R6 cycles_used of first op", 32'(cyc), 32'd3);

    // R1 operands change while busy
    @(negedge clk); start = 1; a = 32'h00AB_CDEF; b = 32'h0033_4455;
    p1 = 32'h00AB_CDEF * 32'h0033_4455;
    @(negedge clk); start = 0; a = 32'hFFFF_FFFF; b = 32'h8765_4321;
    while (busy) @(negedge clk);
    chk(prod == p1, "R1 captured operands", prod, p1);

    // R9 hold while idle
    repeat (5) @(negedge clk);
    chk(prod == p1, "R9 product held", prod, p1);
    chk(cyc == 2'd2, "R9 cycles_used held", 32'(cyc), 32'd2);

    // random mix of magnitudes and signs
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom >> ($urandom % 32);
      if ($urandom % 2) y = ~y;
      run_op(x, y, ref_n(y), y[31] ? "R3 random" : "R2 random");
    end

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule